// File: doc/BRIEF.md
# Work-Stealing Task Distributor

This block hands out task descriptors to a set of workers. Each worker owns a small private queue. A worker files every task it creates into its own queue. When it asks for work, it is served from that same queue, newest task first. Serving a worker from its own queue never waits on any other worker.

When a worker asks for work and its own queue holds nothing, the request turns into a steal. The block scans the other workers in round-robin order, starting just after the requester. It takes the oldest task from the first queue that holds one. Exactly one task moves per steal, and a queue gives up at most one task to thieves in a cycle. If the owner of the chosen queue is itself taking a task in that cycle, the owner is served and the thief receives nothing. The thief simply asks again.

A global completion flag tells the surrounding system when the whole computation has finished. The flag is set when every queue is empty, every worker reports that it is idle, and no worker is offering a new task.

Top module: `wsq_distributor`

## Requirements
- R1: While reset is held, no grant is given, every push_ready is high and done is low. In the first cycle after reset is released, with all workers idle and no push offered, done goes high.
- R2: push_data is taken only into the pushing worker's own queue. The slice for worker w is bits [w*DW +: DW]. push_ready[w] is low exactly when that queue holds DEPTH tasks, and a push offered while push_ready is low is dropped.
- R3: A worker whose own queue is not empty is served from that queue in last-in, first-out order, with pop_stolen low.
- R4: pop_grant[w] pulses high for one cycle, in the cycle after a request is accepted, and pop_data[w*DW +: DW] carries the task in that cycle. A request is refused, with no grant, when no queue holds a task.
- R5: A request from a worker whose own queue is empty takes the oldest task of a victim queue and raises pop_stolen with the grant.
- R6: The victim is the first non-empty queue found when counting upward from the requester's index plus one, wrapping past the last worker back to worker 0.
- R7: If the owner of the victim queue makes a request in the same cycle while its own queue is non-empty, the owner is served and the thief gets no grant in that cycle.
- R8: When several thieves pick the same victim in one cycle, only the thief with the lowest index is served. The others get no grant and may retry.
- R9: done is high in a cycle only if, at the preceding clock edge, every queue was empty, every worker_idle bit was high and no push_valid bit was high.
- R10: A push and a pop by the same worker in one cycle return the task that was newest before that cycle, and the pushed task stays queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | NW | Per-worker offer of a new task |
| push_data | input | NW*DW | Per-worker task descriptor, worker w in bits [w*DW +: DW] |
| push_ready | output | NW | Per-worker queue has room |
| pop_req | input | NW | Per-worker request for a task |
| pop_grant | output | NW | One-cycle grant, one cycle after the request |
| pop_data | output | NW*DW | Task delivered with the grant |
| pop_stolen | output | NW | Granted task came from another worker's queue |
| worker_idle | input | NW | Worker holds no task and is not working |
| done | output | 1 | Global completion |

## Verification
The bench builds the block with four workers, a queue depth of four and eight-bit descriptors. This is small enough that every pattern of non-empty queues can be crossed with every pattern of requests, which gives 256 combinations. Each combination exercises owner priority, the round-robin victim scan with its wraparound, and contention among thieves. A depth of four also lets directed cases fill a queue and offer one extra push. Expected grants and data come from a queue model in the bench that follows the requirements.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
   // index of the worker that lies step places after base, wrapping at n
   function automatic int ring_step(input int base, input int step, input int n);
      return (base + step) % n;
   endfunction
endpackage

// File: rtl/wsq_deque.sv
module wsq_deque #(
   parameter int DEPTH = 4,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_en,
   input  logic [DW-1:0] push_data,
   input  logic          pop_en,
   input  logic          steal_en,
   output logic [DW-1:0] tail_data,
   output logic [DW-1:0] head_data,
   output logic [CW-1:0] count
);
   logic [DW-1:0] slots [DEPTH];
   logic [AW-1:0] head;
   logic [AW-1:0] tail_idx;
   logic [AW-1:0] wr_idx;

   assign tail_idx  = head + AW'(count) - AW'(1);
   // a same-cycle owner pop frees the tail slot for the incoming push
   assign wr_idx    = head + AW'(count) - AW'(pop_en);
   assign tail_data = slots[tail_idx];
   assign head_data = slots[head];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         count <= '0;
      end else begin
         if (steal_en) head <= head + AW'(1);
         count <= count + CW'(push_en) - CW'(pop_en) - CW'(steal_en);
      end
   end

   always_ff @(posedge clk) begin
      if (push_en) slots[wr_idx] <= push_data;
   end
endmodule

// File: rtl/wsq_steal_arb.sv
module wsq_steal_arb #(
   parameter int NW  = 4,
   localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
   input  logic [NW-1:0] pop_req,
   input  logic [NW-1:0] nonempty,
   output logic [NW-1:0] own_pop,
   output logic [NW-1:0] steal_ok,
   output logic [IW-1:0] steal_from [NW],
   output logic [NW-1:0] victim_hit
);
   import wsq_pkg::*;

   logic [NW-1:0] claimed;

   always_comb begin
      logic found;
      int   cand;
      claimed  = '0;
      steal_ok = '0;
      own_pop  = pop_req & nonempty;
      for (int t = 0; t < NW; t++) begin
         steal_from[t] = '0;
         found = 1'b0;
         cand  = 0;
         for (int k = 1; k < NW; k++) begin
            if (!found && nonempty[ring_step(t, k, NW)]) begin
               found = 1'b1;
               cand  = ring_step(t, k, NW);
            end
         end
         if (pop_req[t] && !nonempty[t] && found) begin
            steal_from[t] = IW'(cand);
            // the owner outranks thieves; lower-index thieves claim first
            if (!own_pop[cand] && !claimed[cand]) begin
               steal_ok[t]   = 1'b1;
               claimed[cand] = 1'b1;
            end
         end
      end
      victim_hit = claimed;
   end
endmodule

// File: rtl/wsq_term.sv
module wsq_term #(
   parameter int NW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NW-1:0] nonempty,
   input  logic [NW-1:0] worker_idle,
   input  logic [NW-1:0] push_valid,
   output logic          done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= (nonempty == '0) && (&worker_idle) && (push_valid == '0);
   end
endmodule

// File: rtl/wsq_distributor.sv
module wsq_distributor #(
   parameter int NW    = 4,
   parameter int DEPTH = 4,
   parameter int DW    = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NW-1:0]  push_valid,
   input  logic [NW*DW-1:0] push_data,
   output logic [NW-1:0]  push_ready,
   input  logic [NW-1:0]  pop_req,
   output logic [NW-1:0]  pop_grant,
   output logic [NW*DW-1:0] pop_data,
   output logic [NW-1:0]  pop_stolen,
   input  logic [NW-1:0]  worker_idle,
   output logic           done
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = (NW > 1) ? $clog2(NW) : 1;

   if (NW < 2) begin : g_bad_nw
      $error("wsq_distributor: NW must be at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wsq_distributor: DEPTH must be a power of two, at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("wsq_distributor: DW must be positive");
   end

   logic [CW-1:0] q_cnt [NW];
   logic [DW-1:0] tail_d [NW];
   logic [DW-1:0] head_d [NW];
   logic [DW-1:0] sel_d  [NW];
   logic [NW-1:0] nonempty;
   logic [NW-1:0] push_en;
   logic [NW-1:0] own_pop;
   logic [NW-1:0] steal_ok;
   logic [NW-1:0] victim_hit;
   logic [IW-1:0] steal_from [NW];

   for (genvar w = 0; w < NW; w++) begin : g_worker
      assign nonempty[w]   = (q_cnt[w] != '0);
      assign push_ready[w] = (q_cnt[w] != CW'(DEPTH));
      assign push_en[w]    = push_valid[w] & push_ready[w];
      assign sel_d[w]      = own_pop[w] ? tail_d[w] : head_d[steal_from[w]];

      wsq_deque #(.DEPTH(DEPTH), .DW(DW)) u_q (
         .clk       (clk),
         .rst_n     (rst_n),
         .push_en   (push_en[w]),
         .push_data (push_data[w*DW +: DW]),
         .pop_en    (own_pop[w]),
         .steal_en  (victim_hit[w]),
         .tail_data (tail_d[w]),
         .head_data (head_d[w]),
         .count     (q_cnt[w])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         pop_data[w*DW +: DW] <= '0;
         else if (own_pop[w] | steal_ok[w])  pop_data[w*DW +: DW] <= sel_d[w];
      end
   end

   wsq_steal_arb #(.NW(NW)) u_arb (
      .pop_req    (pop_req),
      .nonempty   (nonempty),
      .own_pop    (own_pop),
      .steal_ok   (steal_ok),
      .steal_from (steal_from),
      .victim_hit (victim_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_grant  <= '0;
         pop_stolen <= '0;
      end else begin
         pop_grant  <= own_pop | steal_ok;
         pop_stolen <= steal_ok;
      end
   end

   wsq_term #(.NW(NW)) u_term (
      .clk         (clk),
      .rst_n       (rst_n),
      .nonempty    (nonempty),
      .worker_idle (worker_idle),
      .push_valid  (push_valid),
      .done        (done)
   );
endmodule

// File: rtl/wsq_distributor_chk.sv
module wsq_distributor_chk #(
   parameter int NW    = 4,
   parameter int DEPTH = 4,
   parameter int CW    = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic [NW-1:0] push_valid,
   input logic [NW-1:0] pop_req,
   input logic [NW-1:0] pop_grant,
   input logic [NW-1:0] pop_stolen,
   input logic [NW-1:0] worker_idle,
   input logic          done,
   input logic [CW-1:0] q_cnt [NW]
);
   logic [NW-1:0] held;
   always_comb begin
      for (int i = 0; i < NW; i++) held[i] = (q_cnt[i] != '0);
   end

   for (genvar w = 0; w < NW; w++) begin : g_chk
      p_grant_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
         pop_grant[w] |-> $past(pop_req[w]));
      p_owner_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (pop_req[w] && q_cnt[w] != '0) |=> (pop_grant[w] && !pop_stolen[w]));
      p_steal_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (pop_grant[w] && pop_stolen[w]) |-> $past(q_cnt[w] == '0));
      p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
         q_cnt[w] <= CW'(DEPTH));
      p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
         int'(q_cnt[w]) <= int'($past(q_cnt[w])) + 1);
   end

   p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past((&worker_idle) && push_valid == '0 && held == '0));
   p_one_steal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pop_grant & pop_stolen) <= $past($countones(held & ~pop_req)));
endmodule

bind wsq_distributor wsq_distributor_chk #(.NW(NW), .DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_valid  (push_valid),
   .pop_req     (pop_req),
   .pop_grant   (pop_grant),
   .pop_stolen  (pop_stolen),
   .worker_idle (worker_idle),
   .done        (done),
   .q_cnt       (q_cnt)
);

// File: tb/wsq_distributor_test.sv
module wsq_distributor_test;
   localparam int NW = 4;
   localparam int DEPTH = 4;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NW-1:0] push_valid = '0;
   logic [NW*DW-1:0] push_data = '0;
   logic [NW-1:0] push_ready;
   logic [NW-1:0] pop_req = '0;
   logic [NW-1:0] pop_grant;
   logic [NW*DW-1:0] pop_data;
   logic [NW-1:0] pop_stolen;
   logic [NW-1:0] worker_idle = '1;
   logic done;

   int n_checks = 0;
   int n_fail = 0;
   logic [DW-1:0] mq [NW][$];

   always #4 clk = ~clk;   // 125 MHz, 8 ns period

   wsq_distributor #(.NW(NW), .DEPTH(DEPTH), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
      .push_ready(push_ready), .pop_req(pop_req), .pop_grant(pop_grant),
      .pop_data(pop_data), .pop_stolen(pop_stolen), .worker_idle(worker_idle),
      .done(done));

   task automatic chk(input longint act, input longint exp, input string tag, input string what);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [NW*DW-1:0] pk(input int w, input logic [DW-1:0] d);
      return (NW*DW)'(d) << (w*DW);
   endfunction

   // one cycle: predict from the queue model, drive, sample after the edge
   task automatic step(input logic [NW-1:0] pv, input logic [NW*DW-1:0] pd, input logic [NW-1:0] pr);
      logic [NW-1:0] eg, es, claimed, er;
      logic [DW-1:0] ed [NW];
      logic edone;
      int sz [NW];
      eg = '0; es = '0; claimed = '0; er = '0;
      edone = (pv == '0) && (&worker_idle);
      for (int w = 0; w < NW; w++) begin
         sz[w] = mq[w].size();
         er[w] = (sz[w] < DEPTH);
         if (sz[w] != 0) edone = 1'b0;
         ed[w] = '0;
         if (pr[w] && sz[w] > 0) begin
            eg[w] = 1'b1;
            ed[w] = mq[w][sz[w]-1];
         end
      end
      for (int t = 0; t < NW; t++) begin
         if (pr[t] && sz[t] == 0) begin
            int v;
            v = -1;
            for (int k = 1; k < NW; k++)
               if (v < 0 && sz[(t+k)%NW] > 0) v = (t+k)%NW;
            if (v >= 0 && !eg[v] && !claimed[v]) begin
               eg[t] = 1'b1; es[t] = 1'b1; claimed[v] = 1'b1;
               ed[t] = mq[v][0];
            end
         end
      end
      for (int w = 0; w < NW; w++) begin
         if (eg[w] && !es[w]) void'(mq[w].pop_back());
         if (claimed[w])      void'(mq[w].pop_front());
      end
      for (int w = 0; w < NW; w++)
         if (pv[w] && sz[w] < DEPTH) mq[w].push_back(pd[w*DW +: DW]);

      push_valid = pv; push_data = pd; pop_req = pr;
      #1;
      chk(push_ready, er, "R2", "push_ready");
      @(posedge clk);
      @(negedge clk);
      chk(pop_grant, eg, "R4", "pop_grant");
      chk(pop_stolen & pop_grant, es, "R5", "pop_stolen");
      for (int w = 0; w < NW; w++)
         if (eg[w]) chk(pop_data[w*DW +: DW], ed[w], "R3", $sformatf("pop_data w%0d", w));
      chk(done, edone, "R9", "done");
      push_valid = '0; pop_req = '0;
   endtask

   task automatic push1(input int w, input logic [DW-1:0] d);
      step(NW'(1) << w, pk(w, d), '0);
   endtask

   task automatic pop1(input int w);
      step('0, '0, NW'(1) << w);
   endtask

   task automatic took(input int w, input logic [DW-1:0] d, input bit st, input string tag);
      chk(pop_grant[w], 1, tag, $sformatf("grant w%0d", w));
      chk(pop_data[w*DW +: DW], d, tag, $sformatf("data w%0d", w));
      chk(pop_stolen[w], st, tag, $sformatf("stolen w%0d", w));
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL R4 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(pop_grant, 0, "R1", "grant in reset");
      chk(push_ready, 4'hF, "R1", "ready in reset");
      chk(done, 0, "R1", "done in reset");
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(done, 1, "R1", "done after reset");

      // R2 / R3: fill worker 0, extra push dropped, LIFO drain
      for (int i = 0; i < DEPTH; i++) push1(0, DW'(8'h10 + i));
      chk(push_ready[0], 0, "R2", "full ready");
      push1(0, 8'h99);
      for (int i = DEPTH - 1; i >= 0; i--) begin
         pop1(0);
         took(0, DW'(8'h10 + i), 0, "R3");
      end
      pop1(0);
      chk(pop_grant, 0, "R4", "no task anywhere");

      // R5 / R6: oldest task stolen, scan wraps
      push1(2, 8'h20); push1(2, 8'h21); push1(2, 8'h22); push1(3, 8'h30);
      pop1(0); took(0, 8'h20, 1, "R5");
      pop1(3); took(3, 8'h30, 0, "R3");
      pop1(3); took(3, 8'h21, 1, "R6");

      // R7: owner beats thief
      step('0, '0, 4'b0110);
      took(2, 8'h22, 0, "R7");
      chk(pop_grant[1], 0, "R7", "thief refused");

      // R8: two thieves on one victim
      push1(3, 8'h40); push1(3, 8'h41);
      step('0, '0, 4'b0110);
      took(1, 8'h40, 1, "R8");
      chk(pop_grant[2], 0, "R8", "higher thief refused");
      pop1(2); took(2, 8'h41, 1, "R8");

      // R10: push and pop together
      push1(1, 8'h50);
      step(4'b0010, pk(1, 8'h51), 4'b0010);
      took(1, 8'h50, 0, "R10");
      pop1(1); took(1, 8'h51, 0, "R10");

      // R9: termination conditions
      push1(1, 8'h60);
      chk(done, 0, "R9", "push offered");
      pop1(1);
      step('0, '0, '0);
      chk(done, 1, "R9", "quiet");
      worker_idle = 4'b1011;
      step('0, '0, '0);
      chk(done, 0, "R9", "worker busy");
      worker_idle = '1;
      step('0, '0, '0);

      // sweep: every non-empty mask against every request mask
      for (int m = 0; m < 16; m++) begin
         for (int r = 0; r < 16; r++) begin
            logic [NW*DW-1:0] pd;
            pd = '0;
            for (int w = 0; w < NW; w++) pd |= pk(w, DW'(8'h80 + 16*w + r));
            step(NW'(m), pd, '0);
            step(NW'(m), pd, NW'(r));
            for (int g = 0; g < 8; g++) begin
               int left;
               left = 0;
               for (int w = 0; w < NW; w++) left += mq[w].size();
               if (left != 0) step('0, '0, '1);
            end
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule